// File: doc/BRIEF.md
# Four-Level Radix Translation Walker

This block turns a 48-bit virtual address into a physical address by walking a four-level radix table kept in memory. A request carries the virtual address and the base of the top-level table. The walker then reads one 8-byte entry per level over a single-outstanding request/response memory port. Each table is 4 KB long and holds 512 entries. The address of each entry is the table base joined with a 9-bit index taken from the virtual address and shifted left by three.

When the last entry is valid, the walker returns its frame number joined with the untouched 12-bit page offset, and passes out the entry's dirty flag. When an entry at any level has a clear valid bit, the walk stops at once. The walker then reports a fault that names the level which failed, and it issues no further reads. A simple busy/done handshake frames each walk. The physical address width is a parameter with a default of 40 bits.

Top module: `page_walker`

## Requirements
- R1: After reset, busy, done, fault and memReqValid are all 0.
- R2: The index for level 1 is vaddr[47:39], level 2 uses vaddr[38:30], level 3 uses vaddr[29:21] and level 4 uses vaddr[20:12]. Each read address equals the table base plus 8 times that level's index.
- R3: The first read goes to the table whose base is rootPtr with its low 12 bits cleared, so those low bits have no effect.
- R4: A valid entry that is not at level 4 supplies the next table base, which is entry bits [PA_W-1:12] followed by 12 zero bits.
- R5: A walk that reaches a valid level-4 entry makes exactly four reads and ends with fault=0. It returns paddr = {entry[PA_W-1:12], vaddr[11:0]}.
- R6: The dirty output equals bit 6 of the level-4 entry on a successful walk.
- R7: An entry with bit 0 (valid) clear at level k ends the walk after exactly k reads. The walker then reports fault=1 and faultLevel=k, where k runs from 1 to 4.
- R8: Each accepted request produces exactly one done pulse, one cycle long. busy is high from the cycle after acceptance until done, and it is low while done is high.
- R9: reqValid is ignored while busy. It causes no extra reads, no extra done, and no change to the result.
- R10: memReqValid is high for one cycle per read. No new read is issued until the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a walk (taken only when idle) |
| reqVaddr | input | 48 | Virtual address to translate |
| rootPtr | input | PA_W | Top-level table base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on an invalid entry |
| faultLevel | output | 3 | Level (1..4) of the invalid entry |
| paddr | output | PA_W | Translated physical address |
| dirty | output | 1 | Dirty flag of the final entry |
| memReqValid | output | 1 | Memory read strobe |
| memReqAddr | output | PA_W | Byte address of the entry read |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 64 | Entry returned by memory |

## Verification
The embedded assertions check on every cycle that a read strobe lasts one cycle, that done is a single-cycle pulse seen only while idle, and that a walk starts only from a request. They also check that a reported fault always names a level from 1 to 4. Only the bench scenarios can show the translation itself. That covers the exact entry addresses at each level and the chaining of table bases. It also covers the number of reads per walk, the joined physical address and dirty flag, the fault level for invalid entries at each of the four levels, and a request raised mid-walk being ignored.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int VA_W      = 48;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 9;
  localparam int LEVELS    = 4;
  localparam int LVL_W     = $clog2(LEVELS);
  localparam int ENTRY_W   = 64;
  localparam int VALID_BIT = 0;
  localparam int DIRTY_BIT = 6;

  typedef struct packed {
    logic loadReq;
    logic issue;
    logic stepLevel;
    logic finishOk;
    logic finishFault;
  } walkStrobes_t;
endpackage

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         memRespValid,
  input  logic         entryValid,
  input  logic         lastLevel,
  output walkStrobes_t strobes,
  output logic         busy,
  output logic         memReqValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walkState_t;
  walkState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: if (reqValid) begin
        strobes.loadReq = 1'b1;
        stateD = ST_ISSUE;
      end
      ST_ISSUE: begin
        strobes.issue = 1'b1;
        stateD = ST_WAIT;
      end
      ST_WAIT: if (memRespValid) begin
        if (!entryValid) begin
          strobes.finishFault = 1'b1;
          stateD = ST_IDLE;
        end else if (lastLevel) begin
          strobes.finishOk = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobes.stepLevel = 1'b1;
          stateD = ST_ISSUE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  assign busy        = (stateQ != ST_IDLE);
  assign memReqValid = strobes.issue;

  // R10: one read strobe per outstanding read
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |=> !memReqValid);

  // R9: a walk only begins in response to a request seen while idle
  assert_start_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reqValid));
endmodule

// File: rtl/walker_dp.sv
module walker_dp
  import walker_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  walkStrobes_t          strobes,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic [PA_W-1:0]       rootPtr,
  input  logic [ENTRY_W-1:0]    memRespData,
  output logic                  entryValid,
  output logic                  lastLevel,
  output logic [PA_W-1:0]       memReqAddr,
  output logic                  done,
  output logic                  fault,
  output logic [LVL_W:0]        faultLevel,
  output logic [PA_W-1:0]       paddr,
  output logic                  dirty
);
  localparam int FRAME_W = PA_W - OFF_W;

  logic [VA_W-1:0]    vaddrQ;
  logic [FRAME_W-1:0] baseQ;
  logic [LVL_W-1:0]   levelQ;
  logic [IDX_W-1:0]   idxArr [LEVELS];
  logic [IDX_W-1:0]   curIdx;
  logic [FRAME_W-1:0] respFrame;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : gen_idx
      assign idxArr[g] = vaddrQ[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
    end
  endgenerate

  assign curIdx     = idxArr[levelQ];
  assign respFrame  = memRespData[PA_W-1:OFF_W];
  assign entryValid = memRespData[VALID_BIT];
  assign lastLevel  = (levelQ == LVL_W'(LEVELS-1));
  assign memReqAddr = {baseQ, curIdx, 3'b000};

  logic unusedInputBits;
  assign unusedInputBits = ^{memRespData[ENTRY_W-1:PA_W], memRespData[OFF_W-1:DIRTY_BIT+1],
                             memRespData[DIRTY_BIT-1:VALID_BIT+1], rootPtr[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddrQ     <= '0;
      baseQ      <= '0;
      levelQ     <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      faultLevel <= '0;
      paddr      <= '0;
      dirty      <= 1'b0;
    end else begin
      done <= strobes.finishOk | strobes.finishFault;
      if (strobes.loadReq) begin
        vaddrQ <= reqVaddr;
        baseQ  <= rootPtr[PA_W-1:OFF_W];
        levelQ <= '0;
      end
      if (strobes.stepLevel) begin
        baseQ  <= respFrame;
        levelQ <= levelQ + 1'b1;
      end
      if (strobes.finishOk) begin
        paddr      <= {respFrame, vaddrQ[OFF_W-1:0]};
        dirty      <= memRespData[DIRTY_BIT];
        fault      <= 1'b0;
        faultLevel <= '0;
      end
      if (strobes.finishFault) begin
        paddr      <= '0;
        dirty      <= 1'b0;
        fault      <= 1'b1;
        faultLevel <= {1'b0, levelQ} + 1'b1;
      end
    end
  end

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a reported fault names a level between 1 and 4
  assert_fault_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (faultLevel != 0 && faultLevel <= (LVL_W+1)'(LEVELS)));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import walker_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic [47:0]     reqVaddr,
  input  logic [PA_W-1:0] rootPtr,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [2:0]      faultLevel,
  output logic [PA_W-1:0] paddr,
  output logic            dirty,
  output logic            memReqValid,
  output logic [PA_W-1:0] memReqAddr,
  input  logic            memRespValid,
  input  logic [63:0]     memRespData
);
  walkStrobes_t strobes;
  logic entryValid, lastLevel;

  walker_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .memRespValid(memRespValid),
    .entryValid(entryValid), .lastLevel(lastLevel), .strobes(strobes),
    .busy(busy), .memReqValid(memReqValid)
  );

  walker_dp #(.PA_W(PA_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .reqVaddr(reqVaddr),
    .rootPtr(rootPtr), .memRespData(memRespData), .entryValid(entryValid),
    .lastLevel(lastLevel), .memReqAddr(memReqAddr), .done(done), .fault(fault),
    .faultLevel(faultLevel), .paddr(paddr), .dirty(dirty)
  );

  // R8: done is only raised once the walker is idle again
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  localparam int PA_W = 40;
  localparam int NV   = 8;
  localparam logic [47:0] VADDRS [NV] = '{
    48'h0000_1234_5678, 48'hFFC0_0000_0ABC, 48'h007F_C000_0123, 48'h1000_3FE0_0456,
    48'h0A00_001F_F789, 48'h8000_0000_0FFF, 48'h1234_5678_9ABC, 48'h0000_0000_0000};
  localparam logic [PA_W-1:0] ROOTS [NV] = '{
    40'h00_0001_0000, 40'h00_0002_3000, 40'h00_0004_5000, 40'h00_0000_1000,
    40'h00_0077_7000, 40'h00_0ABC_D000, 40'hFF_FFFF_F000, 40'h00_0040_0ABC};

  logic clk = 0, rst_n = 0, reqValid = 0;
  logic [47:0] reqVaddr = '0;
  logic [PA_W-1:0] rootPtr = '0;
  logic busy, done, fault, dirty, memReqValid;
  logic [2:0] faultLevel;
  logic [PA_W-1:0] paddr, memReqAddr;
  logic memRespValid = 0;
  logic [63:0] memRespData = '0;

  int checks = 0, failures = 0, cycles = 0, readCount = 0, doneCount = 0;
  logic [PA_W-1:0] readLog [8];
  bit pending = 0;
  int waitLeft = 0;
  logic [PA_W-1:0] pendAddr;

  page_walker #(.PA_W(PA_W)) i_page_walker (.*);

  always #5 clk = ~clk;

  function automatic logic [63:0] memFunc(logic [PA_W-1:0] a);
    logic [8:0] idx = a[11:3];
    logic [PA_W-13:0] fr = a[PA_W-1:12];
    logic [PA_W-13:0] nf = fr * 7 + (PA_W-12)'(idx) + 1;
    logic [63:0] d = {24'hA5A5A5, nf, 12'h0};
    d[2] = 1'b1;
    d[6] = idx[0] ^ idx[1];
    d[0] = (idx != 9'h1FF);
    return d;
  endfunction

  always @(negedge clk) begin
    cycles++;
    memRespValid <= 1'b0;
    if (done) doneCount++;
    if (memReqValid) begin
      if (readCount < 8) readLog[readCount] = memReqAddr;
      readCount++;
      pending = 1; pendAddr = memReqAddr; waitLeft = 1 + readCount % 3;
    end else if (pending) begin
      if (waitLeft == 0) begin
        memRespValid <= 1'b1; memRespData <= memFunc(pendAddr); pending = 0;
      end else waitLeft--;
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic waitDone(output bit ok);
    int n = 0;
    ok = 1;
    while (!done) begin
      @(negedge clk); n++;
      if (n > 200) begin ok = 0; return; end
    end
  endtask

  // Launch one walk; optionally raise a stray request mid-walk (R9).
  task automatic runWalk(logic [47:0] va, logic [PA_W-1:0] root, bit stray);
    logic [PA_W-13:0] fr;
    logic [63:0] d;
    logic [PA_W-1:0] expAddr [4];
    int expReads = 0, expLvl = 0;
    logic [PA_W-1:0] expPa = '0;
    bit expDirty = 0, ok;
    int startDone;
    fr = root[PA_W-1:12];
    for (int lv = 0; lv < 4; lv++) begin
      logic [8:0] idx = va[47 - 9*lv -: 9];
      expAddr[lv] = {fr, idx, 3'b000};
      d = memFunc(expAddr[lv]);
      expReads++;
      if (!d[0]) begin expLvl = lv + 1; break; end
      fr = d[PA_W-1:12];
      if (lv == 3) begin expPa = {fr, va[11:0]}; expDirty = d[6]; end
    end
    @(negedge clk);
    readCount = 0; startDone = doneCount;
    reqVaddr = va; rootPtr = root; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    check(busy === 1'b1, "R8 busy after accept", busy, 1);
    if (stray) begin
      @(negedge clk); @(negedge clk);
      reqVaddr = ~va; rootPtr = ~root; reqValid = 1;
      @(negedge clk);
      reqValid = 0;
    end
    waitDone(ok);
    check(ok, "R8 done seen", ok, 1);
    check(busy === 1'b0, "R8 busy low at done", busy, 0);
    check(readCount == expReads, expLvl != 0 ? "R7 read count" : "R5 read count", readCount, expReads);
    for (int i = 0; i < expReads && i < 4; i++)
      check(readLog[i] === expAddr[i], i == 0 ? "R3 root read addr" : "R2 R4 read addr",
            readLog[i], expAddr[i]);
    if (expLvl != 0) begin
      check(fault === 1'b1, "R7 fault flag", fault, 1);
      check(faultLevel == expLvl, "R7 fault level", faultLevel, expLvl);
    end else begin
      check(fault === 1'b0, "R5 no fault", fault, 0);
      check(paddr === expPa, "R5 paddr", paddr, expPa);
      check(dirty === expDirty, "R6 dirty", dirty, expDirty);
    end
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", done, 0);
    repeat (6) @(negedge clk);
    check(doneCount - startDone == 1, stray ? "R9 single done" : "R8 single done",
          doneCount - startDone, 1);
    check(readCount == expReads, "R9 no extra reads", readCount, expReads);
    check(busy === 1'b0, "R9 stays idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && fault === 0 && memReqValid === 0, "R1 reset state",
          {busy, done, fault, memReqValid}, 0);
    rst_n = 1;
    @(negedge clk);
    reqValid = 0;
    @(negedge clk);
    check(busy === 1'b0 && memReqValid === 1'b0, "R1 idle after reset", busy, 0);
    for (int v = 0; v < NV; v++) runWalk(VADDRS[v], ROOTS[v], 1'b0);
    // R9: stray request during a successful walk and during a faulting one
    runWalk(48'h0000_1234_5678, 40'h00_0001_0000, 1'b1);
    runWalk(48'h0A00_001F_F789, 40'h00_0077_7000, 1'b1);
    // R3: same walk with different low root bits must give the same paddr
    runWalk(48'h0000_1234_5678, 40'h00_0001_0FFF, 1'b0);
    finishRun();
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    finishRun();
  end
endmodule